// File: doc/BRIEF.md
# Receive Frame Statistics Counters

This block keeps a bank of receive statistics for an Ethernet-style receive path. Each time the receive pipeline finishes a frame, it pulses a one-cycle done strobe. With that strobe it presents the frame length with and without the FCS, a two-bit frame class and two control bits. In that cycle the block decides whether the frame is too long and then updates the matching counters on the next rising clock edge.

A frame that is too long is only recorded in a dedicated oversize counter. Every other frame updates the following counters:
- the total and good packet counts;
- one bin of a six-way size histogram;
- two wide octet totals;
- the broadcast or multicast count, when the frame class calls for it.

No counter ever wraps. A counter that is full stays at its all-ones value. Every counter can be read at any time through a combinational word-addressed read port.

Top module: `rx_stat_counters`

## Requirements
- R1: While `frameDone` is low, no counter changes value.
- R2: A frame is oversized when `lenNoFcs` is greater than 16384, or greater than 1522 while `rxCtrl[0]` (long-packet enable) is 0. When `rxCtrl[1]` (store-bad-packet) is 1, no frame is oversized.
- R3: An oversized frame adds 1 to the oversize counter (address 0) and changes no other counter.
- R4: Each accepted frame adds 1 to both the total-packet counter (address 1) and the good-packet counter (address 2).
- R5: An accepted frame adds 1 to exactly one histogram bin, chosen by `lenWithFcs`. The bins and their addresses are: exactly 64 at address 5, 65..127 at 6, 128..255 at 7, 256..511 at 8, 512..1023 at 9, and 1024 or more at 10. A `lenWithFcs` below 64 updates no bin.
- R6: The total-octet and good-octet counters each add `lenNoFcs`+4 per accepted frame. Each is 64 bits wide. The total-octet counter is read with its low word at address 11 and its high word at address 12. The good-octet counter is read with its low word at 13 and its high word at 14.
- R7: Frame class 1 (broadcast) adds 1 to the broadcast counter at address 3. Class 2 (multicast) adds 1 to the multicast counter at address 4. Classes 0 and 3 touch neither counter.
- R8: A packet counter that is at its maximum stays there. An octet counter whose sum would overflow is set to all-ones.
- R9: After reset every counter reads 0. Address 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle strobe: a frame has finished |
| lenNoFcs | input | LEN_W | Frame length without FCS |
| lenWithFcs | input | LEN_W | Frame length including FCS |
| frameType | input | 2 | 0 other, 1 broadcast, 2 multicast, 3 other |
| rxCtrl | input | 2 | bit0 long-packet enable, bit1 store-bad-packet |
| rdAddr | input | 4 | Counter word address |
| rdData | output | 32 | Counter word (combinational) |

## Verification
Two functions can meet in the same frame: a counter reaching saturation, and a frame that the other counters must still record. The bench shrinks the packet counters to 8 bits and the octet counters to 18 bits. It then sends several hundred random frames, so counters reach their limits while frames keep arriving. Each read word is compared against a bench model. The model holds each saturated counter at its maximum and lets every counter that is not yet full keep counting. The oversize thresholds of 1522 and 16384 are also exercised exactly at and one above each limit, under each setting of the control bits.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    FT_OTHER = 2'd0,
    FT_BCAST = 2'd1,
    FT_MCAST = 2'd2,
    FT_RSVD  = 2'd3
  } frameType_e;

  localparam int NUM_BINS     = 6;
  localparam int NUM_PKT_CTRS = 5 + NUM_BINS;
  localparam int IDX_OVERSIZE = 0;
  localparam int IDX_TOTAL    = 1;
  localparam int IDX_GOOD     = 2;
  localparam int IDX_BCAST    = 3;
  localparam int IDX_MCAST    = 4;
  localparam int IDX_HIST0    = 5;

  typedef struct packed {
    logic                incOversize;
    logic                incRx;
    logic                incBcast;
    logic                incMcast;
    logic [NUM_BINS-1:0] histSel;
  } rxStrobe_t;
endpackage

// File: rtl/rxs_sat_ctr.sv
module rxs_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic [W-1:0] addVal,
  output logic [W-1:0] count
);
  logic [W:0] sum;

  assign sum = {1'b0, count} + {1'b0, addVal};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (en) begin
      count <= sum[W] ? '1 : sum[W-1:0];
    end
  end
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int VLAN_MAX  = 1522,
  parameter int JUMBO_MAX = 16384
) (
  input  logic             frameDone,
  input  logic [LEN_W-1:0] lenNoFcs,
  input  logic [LEN_W-1:0] lenWithFcs,
  input  logic [1:0]       frameType,
  input  logic             longPktEn,
  input  logic             storeBad,
  output rxStrobe_t        strb,
  output logic [LEN_W:0]   octInc
);
  logic overLimit;
  logic oversized;
  logic accept;
  logic [NUM_BINS-1:0] binHit;

  for (genvar i = 0; i < NUM_BINS; i++) begin : g_bin
    localparam int LO = (i == 0) ? 64 : ((i == 1) ? 65 : (64 << (i - 1)));
    localparam int HI = (64 << i) - 1;
    if (i == 0) begin : g_exact
      assign binHit[i] = ({1'b0, lenWithFcs} == (LEN_W+1)'(64));
    end else if (i == NUM_BINS - 1) begin : g_top
      assign binHit[i] = ({1'b0, lenWithFcs} >= (LEN_W+1)'(LO));
    end else begin : g_mid
      assign binHit[i] = ({1'b0, lenWithFcs} >= (LEN_W+1)'(LO)) &&
                         ({1'b0, lenWithFcs} <= (LEN_W+1)'(HI));
    end
  end

  always_comb begin
    overLimit = ({1'b0, lenNoFcs} > (LEN_W+1)'(JUMBO_MAX)) ||
                (!longPktEn && ({1'b0, lenNoFcs} > (LEN_W+1)'(VLAN_MAX)));
    oversized = overLimit && !storeBad;
    accept    = frameDone && !oversized;

    strb             = '0;
    strb.incOversize = frameDone && oversized;
    strb.incRx       = accept;
    strb.incBcast    = accept && (frameType == FT_BCAST);
    strb.incMcast    = accept && (frameType == FT_MCAST);
    strb.histSel     = accept ? binHit : '0;
    octInc           = {1'b0, lenNoFcs} + (LEN_W+1)'(4);
  end
endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int OCT_W  = 64,
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [LEN_W:0]    octInc,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DW-1:0]     rdData
);
  localparam int WIDE_W   = 2 * DW;
  localparam int ADR_TOTL = NUM_PKT_CTRS;
  localparam int ADR_GOOD = NUM_PKT_CTRS + 2;

  logic [NUM_PKT_CTRS-1:0] incVec;
  logic [CNT_W-1:0]        pktCnt [NUM_PKT_CTRS];
  logic [OCT_W-1:0]        totOct;
  logic [OCT_W-1:0]        goodOct;
  logic [OCT_W-1:0]        octAdd;
  logic [WIDE_W-1:0]       totWide;
  logic [WIDE_W-1:0]       goodWide;

  always_comb begin
    incVec = '0;
    incVec[IDX_OVERSIZE] = strb.incOversize;
    incVec[IDX_TOTAL]    = strb.incRx;
    incVec[IDX_GOOD]     = strb.incRx;
    incVec[IDX_BCAST]    = strb.incBcast;
    incVec[IDX_MCAST]    = strb.incMcast;
    incVec[IDX_HIST0 +: NUM_BINS] = strb.histSel;
  end

  for (genvar i = 0; i < NUM_PKT_CTRS; i++) begin : g_pkt
    rxs_sat_ctr #(.W(CNT_W)) uCtr (
      .clk    (clk),
      .rstN   (rstN),
      .en     (incVec[i]),
      .addVal (CNT_W'(1)),
      .count  (pktCnt[i])
    );
  end

  assign octAdd = OCT_W'(octInc);

  rxs_sat_ctr #(.W(OCT_W)) uTotOct (
    .clk (clk), .rstN (rstN), .en (strb.incRx), .addVal (octAdd), .count (totOct)
  );

  rxs_sat_ctr #(.W(OCT_W)) uGoodOct (
    .clk (clk), .rstN (rstN), .en (strb.incRx), .addVal (octAdd), .count (goodOct)
  );

  assign totWide  = WIDE_W'(totOct);
  assign goodWide = WIDE_W'(goodOct);

  always_comb begin
    rdData = '0;
    if (int'(rdAddr) < NUM_PKT_CTRS) begin
      rdData = DW'(pktCnt[rdAddr]);
    end else if (int'(rdAddr) == ADR_TOTL) begin
      rdData = totWide[DW-1:0];
    end else if (int'(rdAddr) == ADR_TOTL + 1) begin
      rdData = totWide[WIDE_W-1:DW];
    end else if (int'(rdAddr) == ADR_GOOD) begin
      rdData = goodWide[DW-1:0];
    end else if (int'(rdAddr) == ADR_GOOD + 1) begin
      rdData = goodWide[WIDE_W-1:DW];
    end
  end
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int OCT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic [LEN_W-1:0] lenNoFcs,
  input  logic [LEN_W-1:0] lenWithFcs,
  input  logic [1:0]       frameType,
  input  logic [1:0]       rxCtrl,
  input  logic [3:0]       rdAddr,
  output logic [31:0]      rdData
);
  localparam int DW = 32;

  rxStrobe_t      strb;
  logic [LEN_W:0] octInc;

  rxs_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .frameDone  (frameDone),
    .lenNoFcs   (lenNoFcs),
    .lenWithFcs (lenWithFcs),
    .frameType  (frameType),
    .longPktEn  (rxCtrl[0]),
    .storeBad   (rxCtrl[1]),
    .strb       (strb),
    .octInc     (octInc)
  );

  rxs_datapath #(
    .LEN_W (LEN_W), .CNT_W (CNT_W), .OCT_W (OCT_W), .DW (DW), .ADDR_W (4)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .octInc (octInc),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameDone,
  input logic [LEN_W-1:0] lenNoFcs,
  input logic [1:0]       rxCtrl,
  input logic [3:0]       rdAddr,
  input logic [31:0]      rdData,
  input rxStrobe_t        strb
);
  localparam logic [31:0] MAXW = 32'((64'd1 << CNT_W) - 64'd1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> (strb == '0));  // R1

  AST_SBP_ACCEPTS: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && rxCtrl[1]) |-> (strb.incRx && !strb.incOversize));  // R2

  AST_OVERSIZE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !rxCtrl[1] && (int'(lenNoFcs) > 16384)) |->
      (strb.incOversize && !strb.incRx && strb.histSel == '0));  // R3

  AST_HIST_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.histSel));  // R5

  AST_TYPE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.incBcast && strb.incMcast));  // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rdAddr == 4'd1 && $past(rdAddr) == 4'd1 && $past(rdData) == MAXW)
      |-> (rdData == MAXW));  // R8
endmodule

bind rx_stat_counters rxs_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .frameDone (frameDone),
  .lenNoFcs  (lenNoFcs),
  .rxCtrl    (rxCtrl),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .strb      (strb)
);

// File: tb/rx_stat_counters_test.sv
module rx_stat_counters_test;
  localparam int LEN_W = 16;
  localparam int CNT_W = 8;
  localparam int OCT_W = 18;
  localparam longint MAXC = (64'd1 << CNT_W) - 1;
  localparam longint MAXO = (64'd1 << OCT_W) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic frameDone = 0;
  logic [LEN_W-1:0] lenNoFcs = '0;
  logic [LEN_W-1:0] lenWithFcs = '0;
  logic [1:0] frameType = '0;
  logic [1:0] rxCtrl = '0;
  logic [3:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint ctr [11];
  longint totOct, goodOct;

  always #5 clk = ~clk;

  rx_stat_counters #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W)) uut (
    .clk (clk), .rstN (rstN), .frameDone (frameDone), .lenNoFcs (lenNoFcs),
    .lenWithFcs (lenWithFcs), .frameType (frameType), .rxCtrl (rxCtrl),
    .rdAddr (rdAddr), .rdData (rdData)
  );

  function automatic longint sat(longint v, longint inc, longint mx);
    return (v + inc > mx) ? mx : v + inc;
  endfunction

  function automatic int binOf(int lwf);
    if (lwf == 64) return 0;
    if (lwf >= 65 && lwf <= 127) return 1;
    if (lwf >= 128 && lwf <= 255) return 2;
    if (lwf >= 256 && lwf <= 511) return 3;
    if (lwf >= 512 && lwf <= 1023) return 4;
    if (lwf >= 1024) return 5;
    return -1;
  endfunction

  function automatic longint expWord(int a);
    if (a < 11) return ctr[a];
    case (a)
      11: return totOct & 64'hFFFF_FFFF;
      12: return totOct >> 32;
      13: return goodOct & 64'hFFFF_FFFF;
      14: return goodOct >> 32;
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(int a);
    if (a == 0) return "R3";
    if (a <= 2) return "R4";
    if (a <= 4) return "R7";
    if (a <= 10) return "R5";
    if (a <= 14) return "R6";
    return "R9";
  endfunction

  task automatic modelFrame(int lnf, int lwf, int ft, int ctl);
    bit over;
    int b;
    over = ((lnf > 16384) || (!ctl[0] && lnf > 1522)) && !ctl[1];
    if (over) begin
      ctr[0] = sat(ctr[0], 1, MAXC);
    end else begin
      ctr[1] = sat(ctr[1], 1, MAXC);
      ctr[2] = sat(ctr[2], 1, MAXC);
      if (ft == 1) ctr[3] = sat(ctr[3], 1, MAXC);
      if (ft == 2) ctr[4] = sat(ctr[4], 1, MAXC);
      b = binOf(lwf);
      if (b >= 0) ctr[5 + b] = sat(ctr[5 + b], 1, MAXC);
      totOct  = sat(totOct, lnf + 4, MAXO);
      goodOct = sat(goodOct, lnf + 4, MAXO);
    end
  endtask

  task automatic sendFrame(int lnf, int lwf, int ft, int ctl);
    @(negedge clk);
    lenNoFcs   = LEN_W'(lnf);
    lenWithFcs = LEN_W'(lwf);
    frameType  = 2'(ft);
    rxCtrl     = 2'(ctl);
    frameDone  = 1;
    modelFrame(lnf, lwf, ft, ctl);
    @(negedge clk);
    frameDone = 0;
  endtask

  task automatic checkWord(int a, string ctx);
    longint e;
    rdAddr = 4'(a);
    #1;
    e = expWord(a);
    checks++;
    if (rdData !== 32'(e)) begin
      errors++;
      $display("FAIL %s addr %0d (%s): actual %0d expected %0d", reqOf(a), a, ctx, rdData, e);
    end
  endtask

  task automatic checkAll(string ctx);
    for (int a = 0; a < 16; a++) checkWord(a, ctx);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lnf, lwf, cls;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 11; i++) ctr[i] = 0;
    totOct = 0;
    goodOct = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R9 reset state");

    sendFrame(60, 64, 0, 0);       checkAll("R5 exact 64 bin");
    sendFrame(1522, 1526, 1, 0);   checkAll("R2 at vlan limit accepted, R7 bcast");
    sendFrame(1523, 1527, 2, 0);   checkAll("R2 R3 one above vlan limit");
    sendFrame(1523, 1527, 2, 1);   checkAll("R2 long-packet enable, R7 mcast");
    sendFrame(16384, 16388, 3, 1); checkAll("R2 at jumbo limit");
    sendFrame(16385, 16389, 1, 1); checkAll("R3 over jumbo limit");
    sendFrame(16385, 16389, 1, 2); checkAll("R2 store-bad suppresses check");
    sendFrame(56, 60, 0, 0);       checkAll("R5 below 64 no bin");
    sendFrame(63, 127, 3, 0);      checkAll("R5 127 bin, R7 class 3");
    sendFrame(124, 128, 0, 0);     checkAll("R5 128 bin");
    repeat (6) @(negedge clk);
    checkAll("R1 idle holds");

    for (int n = 0; n < 420; n++) begin
      cls = int'($urandom % 8);
      case (cls)
        0: lnf = 40 + int'($urandom % 30);
        1: lnf = 60 + int'($urandom % 70);
        2: lnf = 124 + int'($urandom % 400);
        3: lnf = 500 + int'($urandom % 600);
        4: lnf = 1000 + int'($urandom % 600);
        5: lnf = 1518 + int'($urandom % 8);
        6: lnf = 16380 + int'($urandom % 8);
        default: lnf = 2000 + int'($urandom % 9000);
      endcase
      lwf = ($urandom % 5 == 0) ? int'($urandom % 2048) : lnf + 4;
      sendFrame(lnf, lwf, int'($urandom % 4), int'($urandom % 4));
      if (n % 30 == 29) checkAll("R4 R6 R8 random mix");
    end
    checkAll("R8 saturation after random run");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule